// File: doc/BRIEF.md
# 16-bit Compare Timer with Byte-Wide Programming

This block is a 16-bit up-counter paired with a 16-bit compare value, both programmed over an 8-bit CPU bus. On every clock where the timer runs and the count-enable tick is present, the counter is checked against the compare value. An equal value is a match. A match always sets a sticky match flag. Each of the following actions can also be enabled on its own: the counter returns to zero instead of stepping, and a waveform pin toggles.

The bus is one byte wide, so the block uses a single shared staging byte to move 16-bit values as a whole. For a write, software writes the upper byte first. That byte goes only into the staging byte. The following lower-byte write then loads the full 16-bit value into the counter or the compare register in one cycle. For a counter read, reading the lower byte copies the counter's upper byte into the staging byte. A later upper-byte read returns that copy, so both halves come from the same instant.

An interrupt request output is the match flag gated by an enable bit. Software clears the flag by writing a one to it.

Top module: `tmr16_timer`

## Requirements
- R1: After reset, the counter, the compare value, the staging byte, the control bits, the match flag, `irq_o` and `wave_o` are all zero.
- R2: The control register is at address 0: bit 0 run, bit 1 clear-on-match, bit 2 toggle-on-match, bit 3 interrupt enable. The counter steps by exactly one (wrapping 0xFFFF to 0x0000) on each clock where run=1 and `tick_i`=1, and holds otherwise.
- R3: A write to address 3 (counter upper) or address 5 (compare upper) loads only the staging byte. The counter and the compare value are unchanged by it.
- R4: A write to address 2 (counter lower) or address 4 (compare lower) loads {staging byte, written byte} into that register in the same cycle. The new value is visible on the next cycle.
- R5: A read of address 2 returns the counter's lower byte and latches its upper byte into the staging byte. A read of address 3 returns the staging byte. Reads of addresses 4 and 5 return the compare value's lower and upper byte directly.
- R6: A match (run=1, `tick_i`=1 and counter equal to compare) sets the match flag, read at address 1 bit 0, on the next cycle. Writing 1 to bit 0 of address 1 clears it. Writing 0 has no effect. A match in the same cycle as a clear wins.
- R7: With clear-on-match set, a match loads the counter with zero instead of stepping it. A CPU counter load in the same cycle takes priority.
- R8: With toggle-on-match set, `wave_o` inverts on the cycle after each match. Otherwise it holds.
- R9: `irq_o` equals the match flag ANDed with the interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable tick |
| bus_we_i | input | 1 | Byte write strobe |
| bus_re_i | input | 1 | Byte read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Match interrupt request |
| wave_o | output | 1 | Match-toggled waveform |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The bench samples it just before the capturing edge, using model state that matches the design's registers at that point. Every register effect (counter step or load, compare load, staging capture, flag set or clear, wave toggle) is due one edge after its stimulus. `irq_o` follows the flag combinationally. The bench therefore advances its reference model on each rising edge and compares `irq_o` and `wave_o` on each falling edge. No check lands on the cycle an update is still in flight.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_FLAG   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CMP_LO = 3'd4,
    A_CMP_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic tgl_en;
    logic clr_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_regif.sv
`timescale 1ns/1ps
module tmr16_regif
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [2:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             flag_i,
  output logic [BUS_W-1:0] rdata_o,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-BUS_W-1:0] tmp_o,
  output logic             cnt_ld_o,
  output logic             cmp_ld_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             flag_clr_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [HI_W-1:0] tmp_q;
  ctrl_t           ctrl_q;
  logic            wr_hi, rd_cnt_lo;

  assign wr_hi     = we_i && (addr_i == A_CNT_HI || addr_i == A_CMP_HI);
  assign rd_cnt_lo = re_i && !we_i && addr_i == A_CNT_LO;

  // shared staging byte: write-high fills it, counter low read snapshots high half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmp_q <= '0;
    else if (wr_hi)     tmp_q <= wdata_i[HI_W-1:0];
    else if (rd_cnt_lo) tmp_q <= cnt_i[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL)   ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign cnt_ld_o   = we_i && addr_i == A_CNT_LO;
  assign cmp_ld_o   = we_i && addr_i == A_CMP_LO;
  assign ld_val_o   = {tmp_q, wdata_i};
  assign flag_clr_o = we_i && addr_i == A_FLAG && wdata_i[0];
  assign ctrl_o     = ctrl_q;
  assign tmp_o      = tmp_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o = BUS_W'(ctrl_q);
      A_FLAG:   rdata_o = BUS_W'(flag_i);
      A_CNT_LO: rdata_o = cnt_i[BUS_W-1:0];
      A_CNT_HI: rdata_o = BUS_W'(tmp_q);
      A_CMP_LO: rdata_o = cmp_i[BUS_W-1:0];
      A_CMP_HI: rdata_o = BUS_W'(cmp_i[CNT_W-1:BUS_W]);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_counter.sv
`timescale 1ns/1ps
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // CPU load wins over counting; clear-on-match replaces the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (step_i) cnt_q <= clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr16_match.sv
`timescale 1ns/1ps
module tmr16_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic             tgl_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             flag_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q, wave_q, hit;

  assign hit = step_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (ld_i) cmp_q <= ld_val_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wave_q <= 1'b0;
    else if (hit && tgl_en_i) wave_q <= ~wave_q;
  end

  assign cmp_o  = cmp_q;
  assign hit_o  = hit;
  assign flag_o = flag_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/tmr16_timer.sv
`timescale 1ns/1ps
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             wave_o
);
  localparam int HI_W = CNT_W - BUS_W;

  ctrl_t            ctrl_q;
  logic [HI_W-1:0]  tmp_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, ld_val;
  logic             cnt_ld, cmp_ld, flag_clr, flag_q, hit, step, wave_q;

  assign step = ctrl_q.run && tick_i;

  tmr16_regif #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .re_i       (bus_re_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt_q),
    .cmp_i      (cmp_q),
    .flag_i     (flag_q),
    .rdata_o    (bus_rdata_o),
    .ctrl_o     (ctrl_q),
    .tmp_o      (tmp_q),
    .cnt_ld_o   (cnt_ld),
    .cmp_ld_o   (cmp_ld),
    .ld_val_o   (ld_val),
    .flag_clr_o (flag_clr)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_ld),
    .ld_val_i (ld_val),
    .step_i   (step),
    .clr_i    (hit && ctrl_q.clr_en),
    .cnt_o    (cnt_q)
  );

  tmr16_match #(.CNT_W(CNT_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (cmp_ld),
    .ld_val_i   (ld_val),
    .cnt_i      (cnt_q),
    .step_i     (step),
    .tgl_en_i   (ctrl_q.tgl_en),
    .flag_clr_i (flag_clr),
    .cmp_o      (cmp_q),
    .hit_o      (hit),
    .flag_o     (flag_q),
    .wave_o     (wave_q)
  );

  assign irq_o  = flag_q && ctrl_q.irq_en;
  assign wave_o = wave_q;
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
module tmr16_chk #(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   we_i,
  input logic [2:0]             addr_i,
  input logic [BUS_W-1:0]       wdata_i,
  input logic [CNT_W-BUS_W-1:0] tmp_q,
  input logic [CNT_W-1:0]       cnt_q,
  input logic [CNT_W-1:0]       cmp_q,
  input logic                   cnt_ld,
  input logic                   step,
  input logic                   hit,
  input logic                   clr_en,
  input logic                   tgl_en,
  input logic                   flag_q,
  input logic                   wave_o
);
  AST_HI_WRITE_NO_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd5) |=> $stable(cmp_q)); // R3
  AST_HI_WRITE_NO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3 && !step) |=> $stable(cnt_q)); // R3
  AST_LO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd4) |=> cmp_q == $past({tmp_q, wdata_i})); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !cnt_ld) |=> $stable(cnt_q)); // R2
  AST_CLR_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_en && !cnt_ld) |=> cnt_q == '0); // R7
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q); // R6
  AST_WAVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && tgl_en) |=> $stable(wave_o)); // R8
endmodule

bind tmr16_timer tmr16_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (bus_we_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .tmp_q   (tmp_q),
  .cnt_q   (cnt_q),
  .cmp_q   (cmp_q),
  .cnt_ld  (cnt_ld),
  .step    (step),
  .hit     (hit),
  .clr_en  (ctrl_q.clr_en),
  .tgl_en  (ctrl_q.tgl_en),
  .flag_q  (flag_q),
  .wave_o  (wave_o)
);

// File: tb/tb_tmr16_timer.sv
`timescale 1ns/1ps
module tb_tmr16_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, wave;

  int n_chk = 0, n_fail = 0;
  int tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tmr16_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wave_o(wave)
  );

  // behavioural reference
  int m_cnt, m_cmp, m_tmp, m_ctrl;
  bit m_flag, m_wave;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_tmp = 0; m_ctrl = 0; m_flag = 0; m_wave = 0;
    end else begin
      bit st, ht;
      int n_cnt, n_cmp, n_tmp, n_ctrl;
      st = m_ctrl[0] && tick;
      ht = st && (m_cnt == m_cmp);
      n_cnt = m_cnt; n_cmp = m_cmp; n_tmp = m_tmp; n_ctrl = m_ctrl;
      if (we && addr == 2) n_cnt = m_tmp * 256 + wdata;
      else if (st) n_cnt = (ht && m_ctrl[1]) ? 0 : (m_cnt + 1) % 65536;
      if (we && addr == 4) n_cmp = m_tmp * 256 + wdata;
      if (we && (addr == 3 || addr == 5)) n_tmp = wdata;
      else if (re && !we && addr == 2) n_tmp = m_cnt / 256;
      if (we && addr == 0) n_ctrl = wdata % 16;
      if (ht) m_flag = 1;
      else if (we && addr == 1 && wdata[0]) m_flag = 0;
      if (ht && m_ctrl[2]) m_wave = !m_wave;
      m_cnt = n_cnt; m_cmp = n_cmp; m_tmp = n_tmp; m_ctrl = n_ctrl;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return int'(m_flag);
      2: return m_cnt % 256;
      3: return m_tmp;
      4: return m_cmp % 256;
      5: return m_cmp / 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle output comparison
  always @(negedge clk) if (rst_n) begin
    chk("R9 irq_o", int'(irq), int'(m_flag && m_ctrl[3]));
    chk("R8 wave_o", int'(wave), int'(m_wave));
  end

  // tick pattern driver
  always @(negedge clk) begin
    #0.5;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? lfsr[0] : 1'b0;
  end

  task automatic bus_idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5; we = 0; re = 0;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #0.5; we = 1; re = 0; addr = 3'(a); wdata = 8'(d);
  endtask

  task automatic rd(int a, string req, output int v);
    @(negedge clk); #0.5; we = 0; re = 1; addr = 3'(a);
    #1;
    v = int'(rdata);
    chk(req, v, exp_rd(a));
  endtask

  int v, hi_snap;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 irq_o", int'(irq), 0);
    chk("R1 wave_o", int'(wave), 0);
    rd(0, "R1 ctrl", v);   chk("R1 ctrl lit", v, 0);
    rd(1, "R1 flag", v);   chk("R1 flag lit", v, 0);
    rd(3, "R1 stage", v);  chk("R1 stage lit", v, 0);
    rd(4, "R1 cmp lo", v); chk("R1 cmp lo lit", v, 0);
    rd(5, "R1 cmp hi", v); chk("R1 cmp hi lit", v, 0);
    rd(2, "R1 cnt lo", v); chk("R1 cnt lo lit", v, 0);
    // R3 high write alone leaves compare untouched
    wr(5, 8'h12);
    rd(5, "R3 cmp hi held", v); chk("R3 cmp hi lit", v, 0);
    rd(4, "R3 cmp lo held", v);
    // R4 low write commits both
    wr(4, 8'h34);
    rd(5, "R4 cmp hi", v); chk("R4 cmp hi lit", v, 8'h12);
    rd(4, "R4 cmp lo", v); chk("R4 cmp lo lit", v, 8'h34);
    // R3/R4 counter path
    wr(3, 8'h12);
    rd(2, "R3 cnt unchanged", v); chk("R3 cnt lit", v, 0);
    wr(3, 8'h12); wr(2, 8'h30);
    rd(2, "R4 cnt lo", v); chk("R4 cnt lo lit", v, 8'h30);
    rd(3, "R4 cnt hi", v); chk("R4 cnt hi lit", v, 8'h12);
    // R2 hold without run
    tick_mode = 1;
    bus_idle(5);
    rd(2, "R2 no run hold", v); chk("R2 hold lit", v, 8'h30);
    // R2/R6/R9 run with irq enable
    wr(0, 4'b1001);
    bus_idle(3);
    rd(2, "R2 counting", v);
    bus_idle(6);
    rd(1, "R6 flag set", v); chk("R6 flag lit", v, 1);
    chk("R9 irq lit", int'(irq), 1);
    wr(1, 0);
    rd(1, "R6 write zero keeps", v); chk("R6 keep lit", v, 1);
    wr(1, 1);
    rd(1, "R6 w1c", v); chk("R6 cleared lit", v, 0);
    // R2 random ticks
    tick_mode = 2;
    bus_idle(10);
    rd(2, "R2 random ticks", v);
    rd(3, "R5 hi after lo", v);
    // R5 coherent snapshot across a high-byte carry
    tick_mode = 0;
    wr(3, 8'h00); wr(2, 8'hF0);
    tick_mode = 1;
    rd(2, "R5 lo read", v);
    bus_idle(40);
    rd(3, "R5 hi snapshot", hi_snap); chk("R5 snapshot lit", hi_snap, 0);
    rd(2, "R5 lo moved", v);
    // R7 clear-on-match, R8 toggle
    tick_mode = 0;
    wr(3, 0); wr(4, 5); wr(3, 0); wr(2, 0);
    wr(0, 4'b0111);
    tick_mode = 1;
    for (int i = 0; i < 20; i++) rd(2, "R7 cnt bounded", v);
    tick_mode = 2;
    bus_idle(30);
    rd(2, "R7 random", v);
    // R8 toggle disabled: wave holds
    wr(0, 4'b0011);
    bus_idle(20);
    // R2 wrap
    tick_mode = 0;
    wr(3, 8'h80); wr(4, 0);
    wr(3, 8'hFF); wr(2, 8'hFE);
    wr(0, 4'b0001);
    tick_mode = 1;
    for (int i = 0; i < 4; i++) rd(2, "R2 wrap", v);
    rd(3, "R2 wrap hi", v);
    // R6 set beats clear: compare at a known count, clear on the match cycle
    tick_mode = 0;
    wr(3, 0); wr(4, 8'h10); wr(3, 0); wr(2, 8'h10);
    wr(1, 1);
    rd(1, "R6 cleared pre", v); chk("R6 pre lit", v, 0);
    tick_mode = 1;
    wr(1, 1);
    rd(1, "R6 set wins", v); chk("R6 set wins lit", v, 1);
    bus_idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R-all watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule